// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic stage of a small 8-bit processor that works on an accumulator. Each cycle it takes the current accumulator value, a second operand, a 4-bit operation code and a valid strobe. From these it produces the new accumulator value and a write strobe in the same cycle. The block keeps five condition flags in its own register: sign, zero, auxiliary (half) carry, parity and carry. The carry/borrow input of the carrying operations comes from the stored carry flag.

The surrounding core uses `accWrite` to decide whether it loads `accOut` into its accumulator. Compare and complement-carry never request a write. The flag register changes on the rising clock edge, and only for an operation that is valid and that affects that flag. The core sees the new flags from the cycle after the operation. Instruction decode, the register file, memory and 16-bit arithmetic sit outside the block.

Top module: `accAlu`

## Requirements
- R1: `opSel` encodes 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 invert accumulator, 9 invert carry, 10 circular rotate left, 11 circular rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 increment, 15 decrement. Add produces accIn + operandIn, and add-with-carry adds the stored carry as well. Both keep the low 8 bits, and CY is set on a carry out of bit 7 (88h + 99h gives 21h, CY=1).
- R2: Subtract produces accIn − operandIn, and subtract-with-borrow subtracts the stored carry as well. Both keep the low 8 bits. CY is set when operandIn plus the borrow-in exceeds accIn.
- R3: For add, subtract (with or without carry), compare, AND, OR, XOR, increment and decrement, the flags are set from the 8-bit result as follows: S equals result bit 7, Z is set when the result is zero, and P is set when the result has an even number of one bits.
- R4: For add-type operations and increment, AC is set on a carry out of bit 3. For subtract-type operations, compare and decrement, AC is set on a borrow into bit 3, that is when the low nibble of the subtrahend plus the borrow-in exceeds the low nibble of accIn.
- R5: Compare sets all five flags exactly as subtract would. It drives accWrite=0 and accOut=accIn.
- R6: AND, OR and XOR clear CY. AND sets AC, and OR and XOR clear AC.
- R7: Invert-accumulator writes ~accIn and leaves every flag unchanged. Invert-carry toggles CY, leaves the other flags unchanged, and drives accWrite=0 with accOut=accIn.
- R8: Rotate left through carry writes {accIn[6:0], CY} and loads accIn[7] into CY. Rotate right through carry writes {CY, accIn[7:1]} and loads accIn[0] into CY.
- R9: Circular rotate left writes {accIn[6:0], accIn[7]} with CY = accIn[7]. Circular rotate right writes {accIn[0], accIn[7:1]} with CY = accIn[0]. Every rotate changes CY only.
- R10: Increment and decrement write accIn ± 1 (mod 256), update S, Z, AC and P, and leave CY unchanged.
- R11: Flags change only on a rising clock edge with opValid=1. While opValid=0 every flag holds, accWrite=0 and accOut=accIn.
- R12: While rstN is low, all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flag register |
| opValid | input | 1 | Execute the operation on opSel this cycle |
| opSel | input | 4 | Operation code (encoding in R1) |
| accIn | input | 8 | Current accumulator value |
| operandIn | input | 8 | Second operand (register or immediate) |
| accOut | output | 8 | New accumulator value (combinational) |
| accWrite | output | 1 | Accumulator should be loaded with accOut |
| flagSign | output | 1 | Stored sign flag |
| flagZero | output | 1 | Stored zero flag |
| flagAux | output | 1 | Stored auxiliary carry flag |
| flagParity | output | 1 | Stored even-parity flag |
| flagCarry | output | 1 | Stored carry/borrow flag |

## Verification
The only state inside the block is the flag register. A wrong stored flag is therefore visible on the flag ports one cycle after the operation that set it. A stale or corrupted carry also shows in the same cycle on accOut of the next add-with-carry, subtract-with-borrow or through-carry rotate that uses it. The reference model in the bench carries its own copy of all five flags forward and compares every port on every cycle. A divergence is reported at most one cycle after it arises, including across cycles with opValid low, where the flags must hold.

// File: rtl/accAluPkg.sv
`timescale 1ns/1ps
package accAluPkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
    OP_CMA = 4'd8, OP_CMC = 4'd9, OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL = 4'd12, OP_RAR = 4'd13, OP_INC = 4'd14, OP_DEC = 4'd15
  } aluOp_e;

  // which unit drives the result bus
  typedef enum logic [2:0] {
    SRC_ADDER, SRC_LOGIC, SRC_INVERT, SRC_ROTATE, SRC_PASS
  } resSrc_e;

  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR } logicOp_e;

  typedef enum logic [1:0] { AUX_ADDER, AUX_ONE, AUX_ZERO } auxSrc_e;

  typedef enum logic [1:0] { CY_ADDER, CY_ZERO, CY_INVERT, CY_ROTATE } carrySrc_e;

  // strobes from control to datapath
  typedef struct packed {
    resSrc_e    resSrc;
    logicOp_e   logicOp;
    auxSrc_e    auxSrc;
    carrySrc_e  carrySrc;
    logic       subtract;     // adder works as a - b - borrow
    logic       carryUse;     // stored carry feeds the adder
    logic       unitOperand;  // adder second input forced to one
    logic       rotLeft;
    logic       rotThru;      // rotate passes through carry
    logic       writeAcc;
    logic       updSzp;
    logic       updAux;
    logic       updCarry;
  } aluStrobes_t;

endpackage

// File: rtl/accAluCtrl.sv
`timescale 1ns/1ps
module accAluCtrl
  import accAluPkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opSel,
  output aluStrobes_t strobes
);

  aluOp_e      op;
  aluStrobes_t raw;

  assign op = aluOp_e'(opSel);

  always_comb begin
    raw          = '0;
    raw.resSrc   = SRC_ADDER;
    raw.logicOp  = LG_AND;
    raw.auxSrc   = AUX_ADDER;
    raw.carrySrc = CY_ADDER;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        raw.subtract = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        raw.carryUse = (op == OP_ADC) || (op == OP_SBB);
        raw.writeAcc = (op != OP_CMP);
        raw.updSzp   = 1'b1;
        raw.updAux   = 1'b1;
        raw.updCarry = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        raw.resSrc   = SRC_LOGIC;
        raw.logicOp  = (op == OP_AND) ? LG_AND : ((op == OP_OR) ? LG_OR : LG_XOR);
        raw.auxSrc   = (op == OP_AND) ? AUX_ONE : AUX_ZERO;
        raw.carrySrc = CY_ZERO;
        raw.writeAcc = 1'b1;
        raw.updSzp   = 1'b1;
        raw.updAux   = 1'b1;
        raw.updCarry = 1'b1;
      end
      OP_CMA: begin
        raw.resSrc   = SRC_INVERT;
        raw.writeAcc = 1'b1;
      end
      OP_CMC: begin
        raw.resSrc   = SRC_PASS;
        raw.carrySrc = CY_INVERT;
        raw.updCarry = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        raw.resSrc   = SRC_ROTATE;
        raw.carrySrc = CY_ROTATE;
        raw.rotLeft  = (op == OP_RLC) || (op == OP_RAL);
        raw.rotThru  = (op == OP_RAL) || (op == OP_RAR);
        raw.writeAcc = 1'b1;
        raw.updCarry = 1'b1;
      end
      OP_INC, OP_DEC: begin
        raw.subtract    = (op == OP_DEC);
        raw.unitOperand = 1'b1;
        raw.writeAcc    = 1'b1;
        raw.updSzp      = 1'b1;
        raw.updAux      = 1'b1;
      end
      default: ;
    endcase
  end

  // an idle cycle neither writes the accumulator nor touches a flag
  always_comb begin
    strobes = raw;
    if (!opValid) begin
      strobes.writeAcc = 1'b0;
      strobes.updSzp   = 1'b0;
      strobes.updAux   = 1'b0;
      strobes.updCarry = 1'b0;
    end
  end

endmodule

// File: rtl/accAluDatapath.sv
`timescale 1ns/1ps
module accAluDatapath
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operandIn,
  output logic [WIDTH-1:0] accOut,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagAux,
  output logic             flagParity,
  output logic             flagCarry
);

  localparam int HALF = WIDTH / 2;

  logic             signQ, zeroQ, auxQ, parityQ, carryQ;
  logic [WIDTH-1:0] bSel, bEff, logicRes, rotRes, result;
  logic [WIDTH:0]   sumFull;
  logic             cIn, adderCarry, adderAux, rotCarry;
  logic             nextAux, nextCarry;

  // shared adder: subtraction runs as a + ~b + ~borrow
  assign bSel       = strobes.unitOperand ? WIDTH'(1) : operandIn;
  assign bEff       = strobes.subtract ? ~bSel : bSel;
  assign cIn        = (strobes.carryUse & carryQ) ^ strobes.subtract;
  assign sumFull    = {1'b0, accIn} + {1'b0, bEff} + (WIDTH + 1)'(cIn);
  assign adderCarry = sumFull[WIDTH] ^ strobes.subtract;
  // carry into the upper half, recovered from the sum bit
  assign adderAux   = sumFull[HALF] ^ accIn[HALF] ^ bEff[HALF] ^ strobes.subtract;

  always_comb begin
    unique case (strobes.logicOp)
      LG_AND:  logicRes = accIn & operandIn;
      LG_OR:   logicRes = accIn | operandIn;
      LG_XOR:  logicRes = accIn ^ operandIn;
      default: logicRes = accIn & operandIn;
    endcase
  end

  always_comb begin
    if (strobes.rotLeft) begin
      rotRes   = {accIn[WIDTH-2:0], strobes.rotThru ? carryQ : accIn[WIDTH-1]};
      rotCarry = accIn[WIDTH-1];
    end else begin
      rotRes   = {strobes.rotThru ? carryQ : accIn[0], accIn[WIDTH-1:1]};
      rotCarry = accIn[0];
    end
  end

  always_comb begin
    unique case (strobes.resSrc)
      SRC_ADDER:  result = sumFull[WIDTH-1:0];
      SRC_LOGIC:  result = logicRes;
      SRC_INVERT: result = ~accIn;
      SRC_ROTATE: result = rotRes;
      default:    result = accIn;
    endcase
  end

  assign accOut = strobes.writeAcc ? result : accIn;

  always_comb begin
    unique case (strobes.auxSrc)
      AUX_ADDER: nextAux = adderAux;
      AUX_ONE:   nextAux = 1'b1;
      default:   nextAux = 1'b0;
    endcase
    unique case (strobes.carrySrc)
      CY_ADDER:  nextCarry = adderCarry;
      CY_ZERO:   nextCarry = 1'b0;
      CY_INVERT: nextCarry = ~carryQ;
      default:   nextCarry = rotCarry;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signQ   <= 1'b0;
      zeroQ   <= 1'b0;
      auxQ    <= 1'b0;
      parityQ <= 1'b0;
      carryQ  <= 1'b0;
    end else begin
      if (strobes.updSzp) begin
        signQ   <= result[WIDTH-1];
        zeroQ   <= (result == '0);
        parityQ <= ~^result;
      end
      if (strobes.updAux)   auxQ   <= nextAux;
      if (strobes.updCarry) carryQ <= nextCarry;
    end
  end

  assign flagSign   = signQ;
  assign flagZero   = zeroQ;
  assign flagAux    = auxQ;
  assign flagParity = parityQ;
  assign flagCarry  = carryQ;

endmodule

// File: rtl/accAlu.sv
`timescale 1ns/1ps
module accAlu
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operandIn,
  output logic [WIDTH-1:0] accOut,
  output logic             accWrite,
  output logic             flagSign,
  output logic             flagZero,
  output logic             flagAux,
  output logic             flagParity,
  output logic             flagCarry
);

  aluStrobes_t strobes;

  accAluCtrl i_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .strobes (strobes)
  );

  accAluDatapath #(.WIDTH(WIDTH)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .accIn      (accIn),
    .operandIn  (operandIn),
    .accOut     (accOut),
    .flagSign   (flagSign),
    .flagZero   (flagZero),
    .flagAux    (flagAux),
    .flagParity (flagParity),
    .flagCarry  (flagCarry)
  );

  assign accWrite = strobes.writeAcc;

endmodule

// File: rtl/accAluChecker.sv
`timescale 1ns/1ps
module accAluChecker
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] accIn,
  input logic [WIDTH-1:0] accOut,
  input logic             accWrite,
  input logic             flagSign,
  input logic             flagZero,
  input logic             flagAux,
  input logic             flagParity,
  input logic             flagCarry
);

  logic [4:0] flagVec;
  assign flagVec = {flagSign, flagZero, flagAux, flagParity, flagCarry};

  // R12: flags cleared while reset is held
  a_r12_reset_clear: assert property (@(posedge clk)
    !rstN |=> (flagVec == 5'b0));

  // R11: idle cycle keeps every flag and requests no write
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagVec));

  a_r11_idle_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!accWrite && accOut == accIn));

  // R5: compare leaves the accumulator alone
  a_r5_cmp_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP) |-> (!accWrite && accOut == accIn));

  // R3: zero flag reflects the written result
  a_r3_zero_follows: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel <= OP_XOR || opSel >= OP_INC)) |=> (flagZero == ($past(accOut) == '0)));

  // R6: logic operations clear carry
  a_r6_logic_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= OP_AND && opSel <= OP_XOR) |=> !flagCarry);

  // R10: increment/decrement keep carry
  a_r10_incdec_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= OP_INC) |=> (flagCarry == $past(flagCarry)));

  // R9: left rotates load carry from bit 7
  a_r9_rotl_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_RLC || opSel == OP_RAL)) |=> (flagCarry == $past(accIn[WIDTH-1])));

  // R8: right rotates load carry from bit 0
  a_r8_rotr_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_RRC || opSel == OP_RAR)) |=> (flagCarry == $past(accIn[0])));

  // R7: invert-accumulator leaves all flags
  a_r7_cma_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMA) |=> $stable(flagVec));

endmodule

bind accAlu accAluChecker #(.WIDTH(WIDTH)) i_accAluChecker (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opSel      (opSel),
  .accIn      (accIn),
  .accOut     (accOut),
  .accWrite   (accWrite),
  .flagSign   (flagSign),
  .flagZero   (flagZero),
  .flagAux    (flagAux),
  .flagParity (flagParity),
  .flagCarry  (flagCarry)
);

// File: tb/test_accAlu.sv
`timescale 1ns/1ps
module test_accAlu;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opSel;
  logic [7:0] accIn, operandIn, accOut;
  logic       accWrite, flagSign, flagZero, flagAux, flagParity, flagCarry;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference flag state
  bit mS = 0, mZ = 0, mA = 0, mP = 0, mC = 0;

  always #10 clk = ~clk;

  accAlu i_accAlu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operandIn(operandIn), .accOut(accOut), .accWrite(accWrite),
    .flagSign(flagSign), .flagZero(flagZero), .flagAux(flagAux),
    .flagParity(flagParity), .flagCarry(flagCarry)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string opTag(input int op);
    case (op)
      0, 1:          return "R1";
      2, 3:          return "R2";
      4, 5, 6:       return "R6";
      7:             return "R5";
      8, 9:          return "R7";
      10, 11:        return "R9";
      12, 13:        return "R8";
      default:       return "R10";
    endcase
  endfunction

  task automatic checkFlags(input string tag);
    check("R3", {tag, " sign"},   flagSign,   mS);
    check("R3", {tag, " zero"},   flagZero,   mZ);
    check("R4", {tag, " aux"},    flagAux,    mA);
    check("R3", {tag, " parity"}, flagParity, mP);
    check(tag,  "carry",          flagCarry,  mC);
  endtask

  // one operation: drive at negedge, check combinational outputs, then flags after the edge
  task automatic step(input int op, input int a, input int b, input bit valid);
    int  r = a;
    bit  wr = 0, uSzp = 0, uAux = 0, uCy = 0, nA = 0, nC = 0;
    int  cin, lo;
    string tag;
    opSel = 4'(op); accIn = 8'(a); operandIn = 8'(b); opValid = valid;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(mC) : 0;
        r = a + b + cin; nC = (r > 255); lo = (a % 16) + (b % 16) + cin; nA = (lo > 15);
        r = r % 256; wr = 1; uSzp = 1; uAux = 1; uCy = 1;
      end
      2, 3, 7: begin
        cin = (op == 3) ? int'(mC) : 0;
        r = a - b - cin; nC = (r < 0); lo = (a % 16) - (b % 16) - cin; nA = (lo < 0);
        r = (r + 512) % 256; wr = (op != 7); uSzp = 1; uAux = 1; uCy = 1;
      end
      4: begin r = a & b; nA = 1; nC = 0; wr = 1; uSzp = 1; uAux = 1; uCy = 1; end
      5: begin r = a | b; nA = 0; nC = 0; wr = 1; uSzp = 1; uAux = 1; uCy = 1; end
      6: begin r = a ^ b; nA = 0; nC = 0; wr = 1; uSzp = 1; uAux = 1; uCy = 1; end
      8: begin r = 255 - a; wr = 1; end
      9: begin nC = !mC; uCy = 1; end
      10: begin r = ((a * 2) % 256) + a / 128; nC = (a / 128) != 0; wr = 1; uCy = 1; end
      11: begin r = a / 2 + (a % 2) * 128; nC = (a % 2) != 0; wr = 1; uCy = 1; end
      12: begin r = ((a * 2) % 256) + int'(mC); nC = (a / 128) != 0; wr = 1; uCy = 1; end
      13: begin r = a / 2 + int'(mC) * 128; nC = (a % 2) != 0; wr = 1; uCy = 1; end
      14: begin r = (a + 1) % 256; nA = (a % 16) == 15; wr = 1; uSzp = 1; uAux = 1; end
      default: begin r = (a + 255) % 256; nA = (a % 16) == 0; wr = 1; uSzp = 1; uAux = 1; end
    endcase
    tag = valid ? opTag(op) : "R11";
    #1;
    check(tag, "accOut",   accOut,   (valid && wr) ? r : a);
    check(tag, "accWrite", accWrite, valid && wr);
    if (valid) begin
      if (uSzp) begin
        mS = (r / 128) != 0; mZ = (r == 0); mP = ($countones(8'(r)) % 2) == 0;
      end
      if (uAux) mA = nA;
      if (uCy)  mC = nC;
    end
    @(negedge clk);
    checkFlags(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 20);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    rstN = 0; opValid = 0; opSel = 0; accIn = 0; operandIn = 0;
    repeat (3) @(negedge clk);
    // R12: flags clear under reset
    check("R12", "flags in reset", {flagSign, flagZero, flagAux, flagParity, flagCarry}, 0);
    check("R12", "accWrite idle", accWrite, 0);
    rstN = 1;
    @(negedge clk);

    // R1: 88h + 99h
    step(0, 'h88, 'h99, 1);
    check("R1", "sum flags SZAPC", {flagSign, flagZero, flagAux, flagParity, flagCarry}, 5'b00111);
    // R1: add-with-carry uses the carry just set
    step(1, 'h88, 'h99, 1);
    // R2: borrow case and borrow-in
    step(2, 'h10, 'h20, 1);
    check("R2", "borrow set", flagCarry, 1);
    step(3, 'h50, 'h10, 1);
    // R5: compare equal gives zero, no write
    step(7, 'h42, 'h42, 1);
    check("R5", "compare equal zero", flagZero, 1);
    // R6 logic
    step(4, 'hF0, 'h0F, 1);
    step(5, 'h00, 'h00, 1);
    step(6, 'hFF, 'h0F, 1);
    // R7: invert carry twice, invert accumulator
    step(9, 'h12, 'h00, 1);
    step(9, 'h12, 'h00, 1);
    step(8, 'h5A, 'h00, 1);
    // R8/R9: rotates
    step(10, 'h81, 0, 1);
    step(13, 'h02, 0, 1);
    step(12, 'h80, 0, 1);
    step(11, 'h01, 0, 1);
    // R10: increment wrap and decrement to zero
    step(14, 'hFF, 0, 1);
    step(15, 'h01, 0, 1);
    step(15, 'h00, 0, 1);
    // R11: idle cycles with a changing opcode
    step(9, 'h33, 'h44, 0);
    step(0, 'hFF, 'hFF, 0);

    for (int i = 0; i < 3000; i++)
      step(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256), ($urandom % 5) != 0);

    finish();
  end

endmodule